// File: doc/BRIEF.md
# Shared-Period Pin Debounce Filter

This block cleans up to 32 already-synchronized input pins before they reach interrupt detection. Three programmable timers each hold a 32-bit period counted in clock cycles. Every pin carries a 2-bit selector. One selector value routes the pin straight through. Each of the other three values ties the pin to one of the timers, and any number of pins may share a timer. A filtered pin changes its clean output only after its raw input has held the new level for the whole selected period. A glitch shorter than the period is therefore dropped. Because software rounds periods upward, the filter never accepts a change early.

Each pin keeps its own stability counter and compares it against the shared period it selects. The counter returns to zero whenever the raw level equals the clean level. It also returns to zero when the pin's selector changes, or when software writes the period of the timer the pin uses. A small register port reads and writes the three periods. Deciding which pins share which timer is left to software.

Top module: `shared_debounce`

## Requirements
- R1: After a synchronous reset the three periods read as 0 and all clean outputs are 0. At the first clock edge after reset is released, every clean output takes the raw value sampled at that edge, with no filtering.
- R2: The timer registers sit at word indices 0, 1 and 2 of `reg_word` (byte offsets 0x0, 0x4 and 0x8). A write with `reg_wr` high stores `reg_wdata` at the clock edge. `reg_rdata` shows the addressed register combinationally. Word index 3 reads 0, and writes to it change no timer.
- R3: Pin i's selector is `pin_sel[2i+1:2i]`, with bit 2i+1 as the high bit. Value 0 selects bypass, and values 1, 2 and 3 select the timers at word indices 0, 1 and 2.
- R4: A bypassed pin's clean output equals its raw input as sampled at the previous clock edge.
- R5: With effective period N, a filtered pin's clean output takes a new level at the N-th consecutive edge that samples that level, and not at the (N-1)-th.
- R6: A pulse on a filtered pin that lasts fewer than N edges leaves the clean output unchanged, and the count starts again from zero once the pulse is over.
- R7: A period of 0 or 1 gives a one-edge filter: the new level is accepted at the first edge that samples it.
- R8: Pins that share one timer count independently, each from the start of its own input change.
- R9: An edge at which a filtered pin's selector differs from its value at the previous edge restarts that pin's count, and its clean output does not change at that edge.
- R10: A period write restarts the count of every filtered pin that selects the written timer, and their clean outputs do not change at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Period register write strobe |
| reg_word | input | 2 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Period write data |
| reg_rdata | output | 32 | Read data for `reg_word` |
| pin_sel | input | 64 | Per-pin 2-bit timer selector |
| pin_raw | input | 32 | Synchronized raw pin levels |
| pin_clean | output | 32 | Debounced pin levels |

## Verification
Every result is registered once. A bypassed pin is due one edge after its input is sampled. A filtered pin with period N is due at the N-th edge that samples the new level. A register write is visible on the combinational read port right after its edge. The bench drives on the falling edge and samples on the next falling edge. For each filtered case it checks the cycle just before the expected edge as well as the edge itself, so a filter that accepts one cycle early or one cycle late is reported. For the restart cases, the selector change or the period write is placed two edges into a count, so a filter that fails to restart updates at a different edge than the expected one.

// File: rtl/shdb_pkg.sv
package shdb_pkg;
    localparam int unsigned TIMER_NUM    = 3;
    localparam int unsigned SEL_W        = 2;
    localparam int unsigned PERIOD_W_DEF = 32;

    typedef enum logic [SEL_W-1:0] {
        SEL_BYPASS = 2'd0,
        SEL_TMR0   = 2'd1,
        SEL_TMR1   = 2'd2,
        SEL_TMR2   = 2'd3
    } sel_e;

    // True when the selector routes the pin through a timer
    function automatic logic sel_filters(input logic [SEL_W-1:0] s);
        return sel_e'(s) != SEL_BYPASS;
    endfunction

    // Timer index addressed by a non-bypass selector
    function automatic logic [SEL_W-1:0] sel_to_timer(input logic [SEL_W-1:0] s);
        return s - SEL_W'(1);
    endfunction
endpackage

// File: rtl/shdb_period_regs.sv
module shdb_period_regs
    import shdb_pkg::*;
#(
    parameter int unsigned PERIOD_W = PERIOD_W_DEF,
    parameter int unsigned WORD_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [WORD_W-1:0]             word,
    input  logic [PERIOD_W-1:0]           wdata,
    output logic [PERIOD_W-1:0]           rdata,
    output logic [TIMER_NUM*PERIOD_W-1:0] periods,
    output logic [TIMER_NUM-1:0]          wr_hit
);
    logic [PERIOD_W-1:0] tmr_q [TIMER_NUM];

    for (genvar t = 0; t < TIMER_NUM; t++) begin : g_tmr
        assign wr_hit[t] = wr_en && (word == WORD_W'(t));
        assign periods[t*PERIOD_W +: PERIOD_W] = tmr_q[t];
    end

    always_ff @(posedge clk) begin
        for (int t = 0; t < TIMER_NUM; t++) begin
            if (rst) begin
                tmr_q[t] <= '0;
            end else if (wr_hit[t]) begin
                tmr_q[t] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int t = 0; t < TIMER_NUM; t++) begin
            if (word == WORD_W'(t)) begin
                rdata = tmr_q[t];
            end
        end
    end
endmodule

// File: rtl/shdb_pin_filter.sv
module shdb_pin_filter
    import shdb_pkg::*;
#(
    parameter int unsigned PERIOD_W = PERIOD_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          prime,
    input  logic                          raw,
    input  logic [SEL_W-1:0]              sel,
    input  logic [TIMER_NUM*PERIOD_W-1:0] periods,
    input  logic [TIMER_NUM-1:0]          wr_hit,
    output logic                          clean
);
    typedef struct packed {
        logic                level;
        logic [PERIOD_W-1:0] count;
        logic [SEL_W-1:0]    sel_q;
    } fstate_t;

    fstate_t             st, st_nx;
    logic                filt;
    logic                restart;
    logic [PERIOD_W-1:0] per;
    logic [PERIOD_W-1:0] limit;
    logic [PERIOD_W-1:0] cnt_inc;

    always_comb begin
        filt    = sel_filters(sel);
        per     = '0;
        restart = (sel != st.sel_q);
        for (int t = 0; t < TIMER_NUM; t++) begin
            if (filt && (sel_to_timer(sel) == SEL_W'(t))) begin
                per     = periods[t*PERIOD_W +: PERIOD_W];
                restart = restart | wr_hit[t];
            end
        end
        limit   = (per == '0) ? PERIOD_W'(1) : per;
        cnt_inc = st.count + PERIOD_W'(1);

        st_nx       = st;
        st_nx.sel_q = sel;
        if (prime || !filt) begin
            st_nx.level = raw;
            st_nx.count = '0;
        end else if ((raw == st.level) || restart) begin
            st_nx.count = '0;
        end else if (cnt_inc >= limit) begin
            st_nx.level = raw;
            st_nx.count = '0;
        end else begin
            st_nx.count = cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.level <= 1'b0;
            st.count <= '0;
            st.sel_q <= sel;
        end else begin
            st <= st_nx;
        end
    end

    assign clean = st.level;
endmodule

// File: rtl/shared_debounce.sv
module shared_debounce
    import shdb_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned PERIOD_W = PERIOD_W_DEF,
    parameter int unsigned WORD_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr,
    input  logic [WORD_W-1:0]         reg_word,
    input  logic [PERIOD_W-1:0]       reg_wdata,
    output logic [PERIOD_W-1:0]       reg_rdata,
    input  logic [NUM_PINS*SEL_W-1:0] pin_sel,
    input  logic [NUM_PINS-1:0]       pin_raw,
    output logic [NUM_PINS-1:0]       pin_clean
);
    logic [TIMER_NUM*PERIOD_W-1:0] period_flat;
    logic [TIMER_NUM-1:0]          wr_hit;
    logic                          primed;

    // First edge after reset loads raw levels directly
    always_ff @(posedge clk) begin
        if (rst) begin
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
        end
    end

    shdb_period_regs #(
        .PERIOD_W (PERIOD_W),
        .WORD_W   (WORD_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .word    (reg_word),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .periods (period_flat),
        .wr_hit  (wr_hit)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        shdb_pin_filter #(
            .PERIOD_W (PERIOD_W)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .prime   (!primed),
            .raw     (pin_raw[i]),
            .sel     (pin_sel[i*SEL_W +: SEL_W]),
            .periods (period_flat),
            .wr_hit  (wr_hit),
            .clean   (pin_clean[i])
        );
    end
endmodule

// File: rtl/shdb_chk.sv
module shdb_chk
    import shdb_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned PERIOD_W = PERIOD_W_DEF,
    parameter int unsigned WORD_W   = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          reg_wr,
    input logic [WORD_W-1:0]             reg_word,
    input logic [PERIOD_W-1:0]           reg_wdata,
    input logic [NUM_PINS*SEL_W-1:0]     pin_sel,
    input logic [NUM_PINS-1:0]           pin_raw,
    input logic [NUM_PINS-1:0]           pin_clean,
    input logic [TIMER_NUM*PERIOD_W-1:0] period_flat
);
    logic                      rst_q;
    logic                      alive;
    logic [NUM_PINS*SEL_W-1:0] sel_q;
    logic [NUM_PINS-1:0]       byp, sel_rs, wr_rs;
    logic                      prime_c;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        sel_q <= pin_sel;
        alive <= !rst;
    end

    assign prime_c = rst_q && !rst;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_mask
        logic [SEL_W-1:0] s;
        assign s         = pin_sel[i*SEL_W +: SEL_W];
        assign byp[i]    = (s == '0);
        assign sel_rs[i] = (s != sel_q[i*SEL_W +: SEL_W]) && (s != '0);
        assign wr_rs[i]  = reg_wr && (s != '0) && (s == SEL_W'(reg_word) + SEL_W'(1));
    end

    assert_prime_R1: assert property (@(posedge clk) disable iff (rst)
        prime_c |=> (pin_clean == $past(pin_raw)));

    for (genvar t = 0; t < TIMER_NUM; t++) begin : g_wr
        assert_store_R2: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_word == WORD_W'(t)) |=>
            (period_flat[t*PERIOD_W +: PERIOD_W] == $past(reg_wdata)));
    end

    assert_unmapped_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_word >= WORD_W'(TIMER_NUM)) |=> $stable(period_flat));

    assert_bypass_R4: assert property (@(posedge clk) disable iff (rst || !alive)
        ((pin_clean ^ $past(pin_raw)) & $past(byp)) == '0);

    assert_change_source_R5: assert property (@(posedge clk) disable iff (rst || !alive)
        ((pin_clean ^ $past(pin_clean)) & (pin_clean ^ $past(pin_raw))) == '0);

    assert_sel_restart_R9: assert property (@(posedge clk) disable iff (rst)
        ((|sel_rs) && !prime_c) |=> (((pin_clean ^ $past(pin_clean)) & $past(sel_rs)) == '0));

    assert_wr_restart_R10: assert property (@(posedge clk) disable iff (rst)
        ((|wr_rs) && !prime_c) |=> (((pin_clean ^ $past(pin_clean)) & $past(wr_rs)) == '0));
endmodule

bind shared_debounce shdb_chk #(
    .NUM_PINS (NUM_PINS),
    .PERIOD_W (PERIOD_W),
    .WORD_W   (WORD_W)
) u_shdb_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_word    (reg_word),
    .reg_wdata   (reg_wdata),
    .pin_sel     (pin_sel),
    .pin_raw     (pin_raw),
    .pin_clean   (pin_clean),
    .period_flat (period_flat)
);

// File: tb/shared_debounce_bench.sv
module shared_debounce_bench;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_wr;
    logic [1:0]    reg_word;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [2*NP-1:0] pin_sel;
    logic [NP-1:0] pin_raw;
    logic [NP-1:0] pin_clean;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shared_debounce u_shared_debounce (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_word  (reg_word),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_sel   (pin_sel),
        .pin_raw   (pin_raw),
        .pin_clean (pin_clean)
    );

    // {raw driven before the edge, clean expected after it}; pin 0 on a period of 3
    localparam logic [1:0] VEC [13] = '{
        2'b10, 2'b10, 2'b11, 2'b01, 2'b11, 2'b01, 2'b01,
        2'b00, 2'b10, 2'b00, 2'b10, 2'b10, 2'b11
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] w, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_word  = w;
        reg_wdata = d;
        tick();
        reg_wr    = 1'b0;
    endtask

    task automatic set_sel(input int p, input logic [1:0] s);
        pin_sel[2*p +: 2] = s;
    endtask

    initial begin
        rst       = 1'b1;
        reg_wr    = 1'b0;
        reg_word  = 2'd0;
        reg_wdata = '0;
        pin_sel   = {NP{2'b01}};
        pin_raw   = 32'hA5A5_0F0F;
        repeat (3) tick();
        chk("R1 clean in reset", pin_clean, 32'h0);
        reg_word = 2'd1;
        #1 chk("R1 period reset", reg_rdata, 32'h0);
        rst = 1'b0;
        tick();
        chk("R1 first sample", pin_clean, 32'hA5A5_0F0F);

        // R4: all pins bypassed, clear the inputs
        pin_sel = '0;
        pin_raw = '0;
        tick();
        chk("R4 bypass all", pin_clean, 32'h0);

        // R2: program and read back
        bus_write(2'd0, 32'd3);
        bus_write(2'd1, 32'd5);
        bus_write(2'd2, 32'd100);
        bus_write(2'd3, 32'hDEAD_BEEF);
        reg_word = 2'd0; #1 chk("R2 read timer0", reg_rdata, 32'd3);
        reg_word = 2'd1; #1 chk("R2 read timer1", reg_rdata, 32'd5);
        reg_word = 2'd2; #1 chk("R2 read timer2", reg_rdata, 32'd100);
        reg_word = 2'd3; #1 chk("R2 unmapped reads 0", reg_rdata, 32'h0);
        @(negedge clk);

        // R5 and R6: table on pin 0 with timer at word 0
        set_sel(0, 2'd1);
        tick();
        for (int i = 0; i < 13; i++) begin
            pin_raw[0] = VEC[i][1];
            tick();
            chk($sformatf("R5/R6 table step %0d", i), 32'(pin_clean[0]), 32'(VEC[i][0]));
        end

        // R4: single bypass pin, one-edge latency
        pin_raw[1] = 1'b1;
        #0 chk("R4 before edge", 32'(pin_clean[1]), 32'h0);
        tick();
        chk("R4 after edge", 32'(pin_clean[1]), 32'h1);

        // R3 and R8: pins 2,3 share word 1 (period 5), pin 4 on word 2 (period 100)
        set_sel(2, 2'd2);
        set_sel(3, 2'd2);
        set_sel(4, 2'd3);
        tick();
        pin_raw[2] = 1'b1;
        pin_raw[4] = 1'b1;
        tick();
        tick();
        pin_raw[3] = 1'b1;
        tick();
        tick();
        chk("R3 pin2 edge 4", 32'(pin_clean[2]), 32'h0);
        tick();
        chk("R3 pin2 edge 5", 32'(pin_clean[2]), 32'h1);
        chk("R8 pin3 independent", 32'(pin_clean[3]), 32'h0);
        tick();
        chk("R8 pin3 edge 4", 32'(pin_clean[3]), 32'h0);
        tick();
        chk("R8 pin3 edge 5", 32'(pin_clean[3]), 32'h1);
        for (int k = 8; k < 100; k++) tick();
        chk("R3 pin4 edge 99", 32'(pin_clean[4]), 32'h0);
        tick();
        chk("R3 pin4 edge 100", 32'(pin_clean[4]), 32'h1);

        // R7: periods 0 and 1
        bus_write(2'd2, 32'd0);
        set_sel(5, 2'd3);
        tick();
        pin_raw[5] = 1'b1;
        tick();
        chk("R7 period 0", 32'(pin_clean[5]), 32'h1);
        bus_write(2'd2, 32'd1);
        pin_raw[5] = 1'b0;
        tick();
        chk("R7 period 1", 32'(pin_clean[5]), 32'h0);

        // R9: selector change restarts the count
        set_sel(6, 2'd1);
        tick();
        pin_raw[6] = 1'b1;
        tick();
        tick();
        set_sel(6, 2'd2);
        tick();
        chk("R9 hold at sel change", 32'(pin_clean[6]), 32'h0);
        repeat (4) tick();
        chk("R9 edge 4 after restart", 32'(pin_clean[6]), 32'h0);
        tick();
        chk("R9 edge 5 after restart", 32'(pin_clean[6]), 32'h1);

        // R10: period write restarts users of that timer
        set_sel(7, 2'd1);
        tick();
        pin_raw[7] = 1'b1;
        tick();
        tick();
        bus_write(2'd0, 32'd3);
        chk("R10 hold at write", 32'(pin_clean[7]), 32'h0);
        tick();
        tick();
        chk("R10 edge 2 after write", 32'(pin_clean[7]), 32'h0);
        tick();
        chk("R10 edge 3 after write", 32'(pin_clean[7]), 32'h1);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule